// File: doc/BRIEF.md
# Profiling Sample Record Filter

This block sits after the capture stage of a statistical profiler and decides, record by record, whether a sampled operation's record should be written out or thrown away. Each record carries an event vector, a set of operation-type flags, the total latency counted from when sampling of that operation began (not just its execution time), and a data-source identifier. The block compares each record against a static set of programmable filters: required events, excluded events, operation-type selects with a per-type AND/OR mode, a latency floor, and a per-source exclusion mask.

A record is presented with `rec_valid` while `rec_ready` is high. Exactly one cycle later the block raises `res_valid` for one cycle, and `res_keep` gives the verdict. A running count of discarded records is kept on `discard_count`. The filter settings are assumed to be held steady while records are in flight.

Top module: `prof_rec_filter`

## Requirements
- R1: A record is discarded unless every bit set in `cfg_evt_need` is also set in `rec_events`.
- R2: A record is discarded if any bit set in `cfg_evt_drop` is also set in `rec_events`; event bit 1 is retired, bit 3 is L1 data refill, bit 5 is TLB refill, bit 7 is mispredict.
- R3: When the same bit is set in both `cfg_evt_need` and `cfg_evt_drop` and the record has that event, the record is discarded.
- R4: Operation flags are bit 0 branch, bit 1 load, bit 2 store, bit 3 SIMD, bit 4 floating point. Selected types whose `cfg_op_and` bit is clear form an OR group: if that group is non-empty, the record must carry at least one of them.
- R5: Every selected type whose `cfg_op_and` bit is set must be present in the record's flags.
- R6: When `cfg_op_sel` is all zero, operation flags have no effect on the verdict.
- R7: A record whose latency is below `cfg_min_lat` is discarded; a latency equal to it passes this test.
- R8: A record whose data-source identifier is N is discarded when bit N of `cfg_src_drop` is set; an all-zero mask excludes no source.
- R9: After reset `rec_ready`, `res_valid` and `res_keep` are low and `discard_count` is zero; `res_valid` rises exactly one cycle after each accepted record, and `res_keep` is low whenever `res_valid` is low.
- R10: `discard_count` increases by one in the same cycle as each result with `res_keep` low and is otherwise unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_evt_need | input | 64 | Events that must all be present |
| cfg_evt_drop | input | 64 | Events any of which discards the record |
| cfg_op_sel | input | 5 | Operation types taking part in filtering |
| cfg_op_and | input | 5 | Per-type AND mode (1) or OR mode (0) |
| cfg_min_lat | input | 12 | Minimum total latency to keep |
| cfg_src_drop | input | 64 | Per-source exclusion mask |
| rec_valid | input | 1 | Record presented |
| rec_ready | output | 1 | Block can accept a record |
| rec_events | input | 64 | Record event vector |
| rec_ops | input | 5 | Record operation-type flags |
| rec_lat | input | 12 | Record total latency |
| rec_src | input | 6 | Record data-source identifier |
| res_valid | output | 1 | Verdict available, one cycle after acceptance |
| res_keep | output | 1 | 1 keep, 0 discard |
| discard_count | output | 16 | Count of discarded records |

## Verification
Every verdict and counter update is due on the clock edge after the one that accepts the record, with a single register stage in between. The bench drives records on falling edges, pushes the model verdict into a queue at that moment, and a monitor on later falling edges pops one entry whenever `res_valid` is seen, so each check lands half a cycle after the update. Back-to-back records confirm that one verdict leaves per cycle and the counter steps once per discard.

// File: rtl/prof_filt_pkg.sv
// Package: shared widths and the operation-type bit order.
// Assumes: the operation flag order below is fixed for all users.
package prof_filt_pkg;
    localparam int OP_N = 5;
    typedef enum int {
        OP_BRANCH = 0,
        OP_LOAD   = 1,
        OP_STORE  = 2,
        OP_SIMD   = 3,
        OP_FP     = 4
    } op_idx_e;
endpackage

// File: rtl/prof_evt_match.sv
// Event test: all required events present and no excluded event present.
// Assumes: purely combinational; exclusion overrides requirement.
module prof_evt_match #(
    parameter int EVT_W = 64
) (
    input  logic [EVT_W-1:0] need,
    input  logic [EVT_W-1:0] drop,
    input  logic [EVT_W-1:0] events,
    output logic             pass
);
    logic need_ok;
    logic drop_hit;

    // Evaluate required and excluded event groups.
    always_comb begin
        need_ok  = ((need & ~events) == '0);
        drop_hit = |(drop & events);
        pass     = need_ok & ~drop_hit;
    end
endmodule

// File: rtl/prof_op_match.sv
// Operation-type test with per-type OR/AND mode.
// Assumes: empty select set bypasses the test; empty OR group passes.
module prof_op_match #(
    parameter int OP_N = prof_filt_pkg::OP_N
) (
    input  logic [OP_N-1:0] sel,
    input  logic [OP_N-1:0] and_mode,
    input  logic [OP_N-1:0] ops,
    output logic            pass
);
    logic [OP_N-1:0] or_hit;
    logic [OP_N-1:0] and_miss;
    logic [OP_N-1:0] or_member;

    // Per-type membership and hit terms.
    for (genvar i = 0; i < OP_N; i++) begin : g_type
        assign or_member[i] = sel[i] & ~and_mode[i];
        assign or_hit[i]    = or_member[i] & ops[i];
        assign and_miss[i]  = sel[i] & and_mode[i] & ~ops[i];
    end

    // Combine the OR group and the AND group.
    always_comb begin
        if (sel == '0) pass = 1'b1;
        else pass = ((or_member == '0) | (|or_hit)) & (and_miss == '0);
    end
endmodule

// File: rtl/prof_lat_src_match.sv
// Latency floor and per-source exclusion test.
// Assumes: source mask has one bit per possible source identifier.
module prof_lat_src_match #(
    parameter int LAT_W = 12,
    parameter int SRC_W = 6,
    localparam int SRC_N = 1 << SRC_W
) (
    input  logic [LAT_W-1:0] min_lat,
    input  logic [SRC_N-1:0] src_drop,
    input  logic [LAT_W-1:0] lat,
    input  logic [SRC_W-1:0] src,
    output logic             pass
);
    // Compare latency and look up the source bit.
    always_comb begin
        pass = (lat >= min_lat) & ~src_drop[src];
    end
endmodule

// File: rtl/prof_rec_filter.sv
// Top: accepts one record per cycle and issues a keep/discard verdict
// one cycle later, counting discards.
// Assumes: cfg_* inputs are stable while records are in flight.
module prof_rec_filter #(
    parameter int EVT_W = 64,
    parameter int LAT_W = 12,
    parameter int SRC_W = 6,
    parameter int CNT_W = 16,
    localparam int SRC_N = 1 << SRC_W,
    localparam int OP_N = prof_filt_pkg::OP_N
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EVT_W-1:0] cfg_evt_need,
    input  logic [EVT_W-1:0] cfg_evt_drop,
    input  logic [OP_N-1:0]  cfg_op_sel,
    input  logic [OP_N-1:0]  cfg_op_and,
    input  logic [LAT_W-1:0] cfg_min_lat,
    input  logic [SRC_N-1:0] cfg_src_drop,
    input  logic             rec_valid,
    output logic             rec_ready,
    input  logic [EVT_W-1:0] rec_events,
    input  logic [OP_N-1:0]  rec_ops,
    input  logic [LAT_W-1:0] rec_lat,
    input  logic [SRC_W-1:0] rec_src,
    output logic             res_valid,
    output logic             res_keep,
    output logic [CNT_W-1:0] discard_count
);
    logic evt_pass, op_pass, ls_pass, accept;

    prof_evt_match #(.EVT_W(EVT_W)) u_evt (
        .need(cfg_evt_need), .drop(cfg_evt_drop),
        .events(rec_events), .pass(evt_pass)
    );

    prof_op_match #(.OP_N(OP_N)) u_op (
        .sel(cfg_op_sel), .and_mode(cfg_op_and),
        .ops(rec_ops), .pass(op_pass)
    );

    prof_lat_src_match #(.LAT_W(LAT_W), .SRC_W(SRC_W)) u_ls (
        .min_lat(cfg_min_lat), .src_drop(cfg_src_drop),
        .lat(rec_lat), .src(rec_src), .pass(ls_pass)
    );

    assign accept = rec_valid & rec_ready;

    // Ready comes up on the first cycle out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) rec_ready <= 1'b0;
        else        rec_ready <= 1'b1;
    end

    // Register the verdict for an accepted record.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_keep  <= 1'b0;
        end else begin
            res_valid <= accept;
            res_keep  <= accept & evt_pass & op_pass & ls_pass;
        end
    end

    // Count records rejected at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) discard_count <= '0;
        else if (accept && !(evt_pass && op_pass && ls_pass))
            discard_count <= discard_count + 1'b1;
    end

    // R9
    res_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid && rec_ready |=> res_valid);
    // R9
    keep_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> !res_keep);
    // R10
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && res_valid && !res_keep |-> discard_count == $past(discard_count) + 1'b1);
    // R10
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !(res_valid && !res_keep) |-> $stable(discard_count));
    // R3
    drop_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid && rec_ready && ((rec_events & cfg_evt_drop) != '0) |=> !res_keep);
    // R7
    lat_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid && rec_ready && (rec_lat < cfg_min_lat) |=> !res_keep);
endmodule

// File: tb/sim_prof_rec_filter.sv
module sim_prof_rec_filter;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [63:0] cfg_evt_need = '0, cfg_evt_drop = '0, cfg_src_drop = '0;
    logic [4:0]  cfg_op_sel = '0, cfg_op_and = '0;
    logic [11:0] cfg_min_lat = '0;
    logic        rec_valid = 1'b0;
    logic        rec_ready;
    logic [63:0] rec_events = '0;
    logic [4:0]  rec_ops = '0;
    logic [11:0] rec_lat = '0;
    logic [5:0]  rec_src = '0;
    logic        res_valid, res_keep;
    logic [15:0] discard_count;

    int checks = 0, fails = 0;
    bit exp_q[$];
    string tag_q[$];
    int exp_disc = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    prof_rec_filter u0 (.*);

    task automatic check(string tag, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit model(logic [63:0] ev, logic [4:0] ops, logic [11:0] lat, logic [5:0] src);
        bit ok = 1;
        bit any_or = 0, or_seen = 0;
        for (int i = 0; i < 64; i++) begin
            if (cfg_evt_need[i] && !ev[i]) ok = 0;
            if (cfg_evt_drop[i] && ev[i]) ok = 0;
        end
        if (cfg_op_sel != 0) begin
            for (int i = 0; i < 5; i++) begin
                if (cfg_op_sel[i] && cfg_op_and[i] && !ops[i]) ok = 0;
                if (cfg_op_sel[i] && !cfg_op_and[i]) begin
                    any_or = 1;
                    if (ops[i]) or_seen = 1;
                end
            end
            if (any_or && !or_seen) ok = 0;
        end
        if (int'(lat) < int'(cfg_min_lat)) ok = 0;
        if (cfg_src_drop[src]) ok = 0;
        return ok;
    endfunction

    // Driver: one record per call, expected verdict pushed to the scoreboard.
    task automatic send(string tag, logic [63:0] ev, logic [4:0] ops, logic [11:0] lat, logic [5:0] src);
        @(negedge clk);
        rec_valid = 1; rec_events = ev; rec_ops = ops; rec_lat = lat; rec_src = src;
        exp_q.push_back(model(ev, ops, lat, src));
        tag_q.push_back(tag);
        @(negedge clk);
        rec_valid = 0;
    endtask

    task automatic drain();
        repeat (3) @(negedge clk);
    endtask

    task automatic clear_cfg();
        cfg_evt_need = '0; cfg_evt_drop = '0; cfg_src_drop = '0;
        cfg_op_sel = '0; cfg_op_and = '0; cfg_min_lat = '0;
    endtask

    // Monitor: pop and compare whenever a verdict appears.
    always @(negedge clk) begin
        if (rst_n) begin
            if (res_valid) begin
                bit e; string t;
                if (exp_q.size() == 0) begin
                    check("R9 unexpected result", 1, 0);
                end else begin
                    e = exp_q.pop_front(); t = tag_q.pop_front();
                    check(t, res_keep, e);
                    if (!e) exp_disc++;
                    check("R10 discard count", discard_count, exp_disc);
                end
            end else begin
                check("R9 keep low when idle", res_keep, 0);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R9 reset ready", rec_ready, 0);
        check("R9 reset valid", res_valid, 0);
        check("R9 reset count", discard_count, 0);
        rst_n = 1;
        @(negedge clk);
        check("R9 ready after reset", rec_ready, 1);

        // R1: require L1D refill (3) and TLB refill (5)
        cfg_evt_need = 64'h28;
        send("R1 both present", 64'h2A, 0, 0, 0);
        send("R1 one missing", 64'h08, 0, 0, 0);
        drain();
        // R2: exclude mispredict (7)
        clear_cfg(); cfg_evt_drop = 64'h80;
        send("R2 mispredict excluded", 64'h82, 0, 0, 0);
        send("R2 other events kept", 64'h0A, 0, 0, 0);
        drain();
        // R3: retired (1) in both masks
        clear_cfg(); cfg_evt_need = 64'h2; cfg_evt_drop = 64'h2;
        send("R3 exclusion wins", 64'h2, 0, 0, 0);
        drain();
        // R4: load or store
        clear_cfg(); cfg_op_sel = 5'b00110;
        send("R4 branch only dropped", 0, 5'b00001, 0, 0);
        send("R4 store kept", 0, 5'b00100, 0, 0);
        drain();
        // R5: store AND simd
        clear_cfg(); cfg_op_sel = 5'b01100; cfg_op_and = 5'b01100;
        send("R5 store only dropped", 0, 5'b00100, 0, 0);
        send("R5 store and simd kept", 0, 5'b01100, 0, 0);
        // R4/R5 mixed: branch|load OR, simd AND
        cfg_op_sel = 5'b01011; cfg_op_and = 5'b01000;
        drain();
        send("R5 mixed load+simd kept", 0, 5'b01010, 0, 0);
        send("R5 mixed load only dropped", 0, 5'b00010, 0, 0);
        send("R4 mixed simd only dropped", 0, 5'b01000, 0, 0);
        drain();
        // R6: no selects
        clear_cfg(); cfg_op_and = 5'b11111;
        send("R6 bypass no flags", 0, 5'b00000, 0, 0);
        drain();
        // R7: latency floor 10
        clear_cfg(); cfg_min_lat = 12'd10;
        send("R7 below floor", 0, 0, 12'd9, 0);
        send("R7 equal floor", 0, 0, 12'd10, 0);
        drain();
        // R8: include only sources 0 and 3
        clear_cfg(); cfg_src_drop = ~64'h9;
        send("R8 source 3 kept", 0, 0, 0, 6'd3);
        send("R8 source 2 dropped", 0, 0, 0, 6'd2);
        drain();
        clear_cfg();
        send("R8 zero mask source 63", 0, 0, 0, 6'd63);
        drain();

        // R9/R10 back-to-back records
        cfg_min_lat = 12'd5;
        @(negedge clk);
        for (int i = 0; i < 6; i++) begin
            rec_valid = 1; rec_lat = 12'(i * 2); rec_src = 0; rec_events = 0; rec_ops = 0;
            exp_q.push_back(model(0, 0, 12'(i * 2), 0));
            tag_q.push_back("R9 back-to-back verdict");
            @(negedge clk);
        end
        rec_valid = 0;
        drain();
        check("R9 all results seen", exp_q.size(), 0);
        check("R10 final count", discard_count, exp_disc);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule